// File: doc/BRIEF.md
# Sample-memory DMA byte mover

This block sits between a host-side DMA channel and a 1 MB local sample memory. It moves one byte per handshake beat, in either direction. Software programs three registers before a transfer:

- a control register, which selects direction, MSB inversion, low-byte pass-through, the terminal-count interrupt and the request bit;
- a start register, counted in 16-byte paragraphs;
- a fine-offset register, whose low four bits add a byte offset.

When the channel is a 16-bit one, the linear offset is folded into the word-addressed layout of the memory. On the final beat the block drops its request. It writes the advanced position back into the start and fine registers. If enabled, it raises an interrupt that a read of the control register acknowledges.

The sequencer has three states: `ST_IDLE`, `ST_ARMED` and `ST_CLOSE`.

- `ST_IDLE` to `ST_ARMED` (arm): taken when the control register is written with the request bit set. The byte offset is frozen at that moment.
- `ST_ARMED` to `ST_CLOSE` (terminal beat): taken when an accepted beat carries the terminal-count flag.
- `ST_ARMED` to `ST_IDLE` (abort): taken when software clears the request bit.
- `ST_CLOSE` to `ST_IDLE` (wrap-up): taken after one cycle, during which the registers and the interrupt are updated.

Register selector codes are 0 for control, 1 for start and 2 for fine offset; code 3 reads zero. Register reads are combinational. Their side effects take place at the clock edge that ends the read cycle.

Top module: `smdma_top`

## Requirements
- R1: After reset the control, start and fine registers read 0 (8-bit channel), `dma_req` is low and `irq` is low.
- R2: On an 8-bit channel the first byte goes to address start*16 + fine[3:0]. Each accepted beat advances the address by one, wrapping within 20 bits.
- R3: On a 16-bit channel the base is (L & 0xC0000) + 2*(L & 0x1FFF0), where L is the linear offset of R2. Bytes then advance by one from that base.
- R4: With control bit 1 at 0 (to card), each accepted beat asserts `mem_we` with the converted host byte. With bit 1 at 1 (to host), each beat asserts `mem_re`, `host_rdata` equals `mem_rdata`, and `mem_we` stays low.
- R5: Control bit 7 inverts bit 7 of each byte written toward card memory. Bytes read toward the host are never altered.
- R6: Control bit 6 passes the low byte unaltered: on a 16-bit channel even-numbered bytes are kept while odd bytes are still inverted; on an 8-bit channel every byte is kept.
- R7: Writing control with bit 0 set while idle raises `dma_req` at the next cycle. Beats offered while `dma_req` is low cause no memory access and change no register.
- R8: The beat carrying `beat_tc` is the last. `dma_req` is low in the following cycle, and control bit 0 reads 0 one cycle after that.
- R9: At terminal count, start advances by N>>4 and fine becomes (N + fine[3:0]) & 0xF. N is the number of bytes on an 8-bit channel and of byte pairs on a 16-bit channel.
- R10: At terminal count, with control bit 5 set, `irq` rises two cycles after the terminal beat. With bit 5 clear, `irq` stays low.
- R11: A control read returns stored bit 6 ORed with the pending terminal-count flag, and stored bit 2 ORed with the 16-bit channel flag. The read clears the pending flag, so `irq` is low in the next cycle. It also clears stored bits 6 and 2.
- R12: Writing the start register clears fine-offset bits 7:4 and keeps bits 3:0.
- R13: Clearing control bit 0 while armed returns the block to idle. There is then no interrupt and no start or fine update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_chan | input | 1 | Host channel is 16 bits wide |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on control) |
| reg_sel | input | 2 | Register selector: 0 control, 1 start, 2 fine |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| dma_req | output | 1 | Request to the host DMA engine; beats accepted while high |
| beat_vld | input | 1 | Host offers one byte beat |
| beat_tc | input | 1 | Beat is the terminal-count beat |
| host_wdata | input | 8 | Byte from host toward card memory |
| host_rdata | output | 8 | Byte from card memory toward host |
| mem_addr | output | 20 | Sample memory byte address |
| mem_we | output | 1 | Sample memory write enable |
| mem_re | output | 1 | Sample memory read enable |
| mem_wdata | output | 8 | Sample memory write data |
| mem_rdata | input | 8 | Sample memory read data (combinational) |
| irq | output | 1 | Terminal-count interrupt |

## Verification
A table of six transfers varies the channel width, the start and fine values, the conversion bits and the length. A linear offset and a folded one are therefore told apart, and a carry into the start register (37 and 64 units) is separated from a fine-only change. A start value at the top of memory shows the 20-bit wrap. Each transfer also checks one conversion case: inversion alone, inversion with low-byte pass-through on both widths, and inversion requested on a read toward the host. These show whether the conversion picks the right bytes and honours direction. Directed runs then separate acknowledge from completion: a read after an interrupting transfer, a second read, beats offered while idle, and an abort mid-transfer.

// File: rtl/smdma_pkg.sv
package smdma_pkg;
    localparam int BIT_REQ    = 0;
    localparam int BIT_DIR    = 1;
    localparam int BIT_WIDE   = 2;
    localparam int BIT_TCIE   = 5;
    localparam int BIT_LOCOPY = 6;
    localparam int BIT_INV    = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CLOSE = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_START = 2'd1,
        SEL_FINE  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/smdma_addr_map.sv
module smdma_addr_map #(
    parameter int ADDR_W  = 20,
    parameter int START_W = 16
) (
    input  logic [START_W-1:0] start,
    input  logic [3:0]         fine,
    input  logic               wide,
    output logic [ADDR_W-1:0]  base
);
    localparam int LIN_W = START_W + 4;
    localparam int MID_W = ADDR_W - 7;

    logic [LIN_W-1:0]  lin;
    logic [ADDR_W-1:0] lin_a;
    logic [ADDR_W-1:0] hi_part;
    logic [ADDR_W-1:0] mid_part;

    always_comb begin
        lin      = {start, 4'b0000} + LIN_W'(fine);
        lin_a    = ADDR_W'(lin);
        // keep the two top bits, drop the byte nibble, double the rest
        hi_part  = lin_a & {2'b11, {(ADDR_W-2){1'b0}}};
        mid_part = (lin_a & {3'b000, {MID_W{1'b1}}, 4'b0000}) << 1;
        base     = wide ? (hi_part + mid_part) : lin_a;
    end
endmodule

// File: rtl/smdma_byte_conv.sv
module smdma_byte_conv (
    input  logic       to_card,
    input  logic       inv_en,
    input  logic       locopy,
    input  logic       wide,
    input  logic       byte_odd,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic low_pos;
    logic flip;

    always_comb begin
        low_pos = wide ? ~byte_odd : 1'b1;
        flip    = inv_en & to_card & ~(locopy & low_pos);
        dout    = flip ? (din ^ 8'h80) : din;
    end
endmodule

// File: rtl/smdma_seq.sv
module smdma_seq
    import smdma_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              req_bit,
    input  logic              beat_vld,
    input  logic              beat_tc,
    input  logic              wide,
    output seq_state_t        state,
    output logic [ADDR_W-1:0] cursor,
    output logic [ADDR_W-1:0] units,
    output logic              accept,
    output logic              closing
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (arm) nxt = ST_ARMED;
            ST_ARMED: begin
                if (accept && beat_tc) nxt = ST_CLOSE;
                else if (!req_bit)     nxt = ST_IDLE;
            end
            ST_CLOSE: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        accept  = (state == ST_ARMED) && beat_vld;
        closing = (state == ST_CLOSE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cursor <= '0;
            units  <= '0;
        end else if (state == ST_IDLE && arm) begin
            cursor <= '0;
            units  <= '0;
        end else if (accept) begin
            cursor <= cursor + 1'b1;
            if (!wide || cursor[0]) units <= units + 1'b1;
        end
    end

    AST_CLOSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CLOSE |=> state == ST_IDLE); // R8
    AST_CURSOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> cursor == $past(cursor) + 1'b1); // R2
    AST_ARM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && arm) |=> (cursor == '0 && units == '0)); // R9
endmodule

// File: rtl/smdma_top.sv
module smdma_top
    import smdma_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int START_W = 16,
    parameter int FINE_W  = 8,
    parameter int CTRL_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wide_chan,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [1:0]         reg_sel,
    input  logic [START_W-1:0] reg_wdata,
    output logic [START_W-1:0] reg_rdata,
    output logic               dma_req,
    input  logic               beat_vld,
    input  logic               beat_tc,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_we,
    output logic               mem_re,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    output logic               irq
);
    logic [CTRL_W-1:0]  ctrl_q;
    logic [START_W-1:0] start_q;
    logic [FINE_W-1:0]  fine_q;
    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  base_now;
    logic [ADDR_W-1:0]  cursor;
    logic [ADDR_W-1:0]  units;
    logic               tc_pend;
    logic               accept;
    logic               closing;
    logic               arm;
    seq_state_t         st;
    reg_sel_t           sel;

    assign sel = reg_sel_t'(reg_sel);
    assign arm = reg_wr && (sel == SEL_CTRL) && reg_wdata[BIT_REQ] && (st == ST_IDLE);

    smdma_addr_map #(.ADDR_W(ADDR_W), .START_W(START_W)) map_i (
        .start (start_q),
        .fine  (fine_q[3:0]),
        .wide  (wide_chan),
        .base  (base_now)
    );

    smdma_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .req_bit  (ctrl_q[BIT_REQ]),
        .beat_vld (beat_vld),
        .beat_tc  (beat_tc),
        .wide     (wide_chan),
        .state    (st),
        .cursor   (cursor),
        .units    (units),
        .accept   (accept),
        .closing  (closing)
    );

    smdma_byte_conv conv_i (
        .to_card  (~ctrl_q[BIT_DIR]),
        .inv_en   (ctrl_q[BIT_INV]),
        .locopy   (ctrl_q[BIT_LOCOPY]),
        .wide     (wide_chan),
        .byte_odd (cursor[0]),
        .din      (host_wdata),
        .dout     (mem_wdata)
    );

    always_comb begin
        dma_req    = (st == ST_ARMED);
        mem_addr   = base_q + cursor;
        mem_we     = accept && !ctrl_q[BIT_DIR];
        mem_re     = accept &&  ctrl_q[BIT_DIR];
        host_rdata = mem_rdata;
        irq        = tc_pend;
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:  reg_rdata = START_W'({ctrl_q[7], ctrl_q[6] | tc_pend, ctrl_q[5:3],
                                             ctrl_q[2] | wide_chan, ctrl_q[1:0]});
            SEL_START: reg_rdata = start_q;
            SEL_FINE:  reg_rdata = START_W'(fine_q);
            default:   reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            start_q <= '0;
            fine_q  <= '0;
            base_q  <= '0;
            tc_pend <= 1'b0;
        end else begin
            if (arm) base_q <= base_now;
            // read acknowledge first, completion and writes take precedence
            if (reg_rd && sel == SEL_CTRL) begin
                ctrl_q[BIT_LOCOPY] <= 1'b0;
                ctrl_q[BIT_WIDE]   <= 1'b0;
                tc_pend            <= 1'b0;
            end
            if (closing) begin
                start_q         <= start_q + START_W'(units >> 4);
                fine_q          <= {{(FINE_W-4){1'b0}}, 4'(units[3:0] + fine_q[3:0])};
                ctrl_q[BIT_REQ] <= 1'b0;
                if (ctrl_q[BIT_TCIE]) tc_pend <= 1'b1;
            end
            if (reg_wr) begin
                unique case (sel)
                    SEL_CTRL:  ctrl_q <= reg_wdata[CTRL_W-1:0];
                    SEL_START: begin
                        start_q              <= reg_wdata;
                        fine_q[FINE_W-1:4]   <= '0;
                    end
                    SEL_FINE:  fine_q <= reg_wdata[FINE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(st) == ST_CLOSE && $past(ctrl_q[BIT_TCIE]))); // R10
    AST_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel == SEL_CTRL && st != ST_CLOSE) |=> !irq); // R11
    AST_FINE_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_START) |=> fine_q[FINE_W-1:4] == '0); // R12
    AST_WIDE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && $past(st) == ST_IDLE && $past(wide_chan)) |-> base_q[4:0] == 5'd0); // R3
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLOSE && !(reg_wr && sel == SEL_CTRL)) |=> !ctrl_q[BIT_REQ]); // R8
endmodule

// File: tb/smdma_top_tb_top.sv
`timescale 1ns/1ps
module smdma_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_chan = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        dma_req;
    logic        beat_vld = 1'b0;
    logic        beat_tc = 1'b0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic [19:0] mem_addr;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

    smdma_top dut_i (
        .clk(clk), .rst_n(rst_n), .wide_chan(wide_chan), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
        .beat_vld(beat_vld), .beat_tc(beat_tc), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        wide;
        logic [7:0]  ctrl;
        logic [15:0] start;
        logic [7:0]  fine;
        logic [7:0]  nbeats;
        logic [19:0] first;
        logic [15:0] nstart;
        logic [7:0]  nfine;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h01, 16'h1234, 8'h05, 8'd3,  20'h12345, 16'h1234, 8'h08},
        '{1'b0, 8'h81, 16'h0100, 8'h93, 8'd37, 20'h01003, 16'h0102, 8'h08},
        '{1'b0, 8'hC1, 16'hFFFF, 8'h0E, 8'd4,  20'hFFFFE, 16'hFFFF, 8'h02},
        '{1'b1, 8'hC1, 16'h1234, 8'h05, 8'd4,  20'h24680, 16'h1234, 8'h07},
        '{1'b1, 8'h81, 16'hF000, 8'h00, 8'd64, 20'hE0000, 16'hF002, 8'h00},
        '{1'b0, 8'h83, 16'h0020, 8'h01, 8'd5,  20'h00201, 16'h0020, 8'h06}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] d);
        reg_sel = s; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [7:0] exp_byte(input logic wide, input logic [7:0] c,
                                            input int i, input logic [7:0] d);
        logic mask;
        logic low;
        mask = c[7] & ~c[1];
        low  = wide ? (i % 2 == 0) : 1'b1;
        if (mask && !(c[6] && low)) return d ^ 8'h80;
        return d;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 dma_req", 32'(dma_req), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(2'd0, rv); chk("R1 ctrl", 32'(rv), 0);
        rd(2'd1, rv); chk("R1 start", 32'(rv), 0);
        rd(2'd2, rv); chk("R1 fine", 32'(rv), 0);

        // R7 beats while idle are ignored
        wr(2'd1, 16'h0033);
        beat_vld = 1'b1; beat_tc = 1'b1; host_wdata = 8'h11;
        #1 chk("R7 idle no write", 32'(mem_we), 0);
        chk("R7 idle no read", 32'(mem_re), 0);
        @(posedge clk); @(negedge clk);
        beat_vld = 1'b0; beat_tc = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R7 idle no req", 32'(dma_req), 0);
        rd(2'd1, rv); chk("R7 start unchanged", 32'(rv), 32'h0033);
        rd(2'd2, rv); chk("R7 fine unchanged", 32'(rv), 0);

        // table of transfers: R2 R3 R4 R5 R6 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            wide_chan = VECS[v].wide;
            wr(2'd1, VECS[v].start);
            wr(2'd2, {8'h00, VECS[v].fine});
            wr(2'd0, {8'h00, VECS[v].ctrl});
            chk("R7 req raised", 32'(dma_req), 1);
            for (int i = 0; i < int'(VECS[v].nbeats); i++) begin
                logic [19:0] ea;
                logic [7:0] d;
                d = 8'(i * 37 + 8'h5C);
                ea = 20'(VECS[v].first + 20'(i));
                beat_vld = 1'b1; host_wdata = d;
                beat_tc = (i == int'(VECS[v].nbeats) - 1);
                #1;
                chk(VECS[v].wide ? "R3 addr" : "R2 addr", 32'(mem_addr), 32'(ea));
                if (VECS[v].ctrl[1]) begin
                    chk("R4 read enable", {30'd0, mem_we, mem_re}, 32'd1);
                    chk("R5 read unaltered", 32'(host_rdata), 32'(ea[7:0] ^ 8'hA5));
                end else begin
                    chk("R4 write enable", {30'd0, mem_we, mem_re}, 32'd2);
                    chk("R6 R5 write data", 32'(mem_wdata),
                        32'(exp_byte(VECS[v].wide, VECS[v].ctrl, i, d)));
                end
                @(posedge clk); @(negedge clk);
            end
            beat_vld = 1'b0; beat_tc = 1'b0;
            chk("R8 req drops", 32'(dma_req), 0);
            @(posedge clk); @(negedge clk);
            chk("R10 no irq without enable", 32'(irq), 0);
            rd(2'd1, rv); chk("R9 start", 32'(rv), 32'(VECS[v].nstart));
            rd(2'd2, rv); chk("R9 fine", 32'(rv), 32'(VECS[v].nfine));
            rd(2'd0, rv);
            chk("R8 ctrl bit0 clear", 32'(rv),
                32'((VECS[v].ctrl & 8'hFE) | (VECS[v].wide ? 8'h04 : 8'h00)));
        end

        // R10 and R11: interrupting transfer on a wide channel
        wide_chan = 1'b1;
        wr(2'd1, 16'h0010);
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h0021);
        for (int i = 0; i < 2; i++) begin
            beat_vld = 1'b1; beat_tc = (i == 1); host_wdata = 8'(i);
            @(posedge clk); @(negedge clk);
        end
        beat_vld = 1'b0; beat_tc = 1'b0;
        chk("R10 irq not yet", 32'(irq), 0);
        @(posedge clk); @(negedge clk);
        chk("R10 irq raised", 32'(irq), 1);
        rd(2'd0, rv); chk("R11 read pending", 32'(rv), 32'h64);
        chk("R11 irq acked", 32'(irq), 0);
        rd(2'd0, rv); chk("R11 second read", 32'(rv), 32'h24);

        // R11 stored bits 6 and 2 cleared by a read
        wide_chan = 1'b0;
        wr(2'd0, 16'h0044);
        rd(2'd0, rv); chk("R11 stored bits", 32'(rv), 32'h44);
        rd(2'd0, rv); chk("R11 stored cleared", 32'(rv), 32'h00);

        // R12 start write trims fine
        wr(2'd2, 16'h00A7);
        rd(2'd2, rv); chk("R12 fine full", 32'(rv), 32'hA7);
        wr(2'd1, 16'h0042);
        rd(2'd2, rv); chk("R12 fine trimmed", 32'(rv), 32'h07);

        // R13 abort
        wr(2'd1, 16'h0050);
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h0021);
        beat_vld = 1'b1; beat_tc = 1'b0; host_wdata = 8'h77;
        @(posedge clk); @(negedge clk);
        beat_vld = 1'b0;
        wr(2'd0, 16'h0020);
        @(posedge clk); @(negedge clk);
        chk("R13 req dropped", 32'(dma_req), 0);
        @(posedge clk); @(negedge clk);
        chk("R13 no irq", 32'(irq), 0);
        rd(2'd1, rv); chk("R13 start kept", 32'(rv), 32'h0050);
        rd(2'd2, rv); chk("R13 fine kept", 32'(rv), 32'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule